// File: doc/BRIEF.md
# Descriptor DMA Channel Control and Status Registers

This block holds the software-visible control and status state for a bank of descriptor-driven DMA channels. It sits on a simple 32-bit register bus. Writes are single-cycle and reads are combinational. Each channel owns a 128-byte address window. Bits 7 and up of the byte address pick the channel. Bits 6:2 pick a word inside that window.

Software never writes the status word directly. It writes a control word instead, and the upper half of that word is a bit mask. The mask says which status bits take the value carried in the lower half. After that masked merge, the block derives the channel's ACTIVE and DEAD flags from the RUN, PAUSE and WAKE controls. The block also holds each channel's command pointer. It locks the pointer while the channel runs, and aligns it to 16 bytes when it accepts a write.

Each channel has a one-cycle fetch-start pulse for the descriptor sequencer. The pulse fires when a pointer write is accepted, or when a control write leaves the channel active. The sequencer reports a fatal error back to this block through a kill request.

Top module: `dmaChanCtrlRegs`

## Requirements
- R1: After reset every register of every channel reads as zero, `fetchStart` is all zero, and `chActive` is all zero.
- R2: A write to word 0 of a channel (the control word) uses wrData[31:16] as a mask and wrData[15:0] as values. Only status bits 15 (RUN), 14 (PAUSE), 13 (FLUSH), 12 (WAKE) and 7:0 (device status) can change. Where the mask is 1 a bit takes the value; elsewhere it keeps its old state. Bits 11 (DEAD), 10 (ACTIVE) and 8 (branch-taken) are never changed by a control write's mask.
- R3: After the masked merge, three rules apply in this order. WAKE=1 sets ACTIVE. Then RUN=1 sets ACTIVE and clears DEAD. Then PAUSE=1 clears ACTIVE, so PAUSE wins.
- R4: A control write that takes RUN from 1 to 0 clears both ACTIVE and DEAD.
- R5: A write to word 2 (the command pointer) is ignored while the channel's RUN or ACTIVE bit is set.
- R6: An accepted command-pointer write stores wrData with bits 3:0 forced to zero. It raises that channel's `fetchStart` bit for exactly one cycle, starting the cycle after the write.
- R7: A control write that leaves ACTIVE set raises that channel's `fetchStart` bit for exactly one cycle after the write. A control write that leaves ACTIVE clear raises no pulse.
- R8: Read behaviour by word:
  - word 0 reads 0;
  - word 1 returns the 16-bit status, zero-extended;
  - words 2, 3 (interrupt select), 4 (branch select) and 5 (wait select) read back as stored;
  - words 6 to 31 read 0;
  - writes to word 1 and to words 6 to 31 have no effect.
- R9: The channel is addr[ADDR_W-1:7] and the word is addr[6:2]. A write to one channel leaves every other channel's registers unchanged.
- R10: A `killReq` bit high for one cycle sets that channel's DEAD bit and clears its ACTIVE bit on the next edge, with no fetch pulse. It is applied after any control write in the same cycle.
- R11: `chActive[c]` always equals bit 10 (ACTIVE) of channel c's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; channel in bits 7 and up |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| killReq | input | NUM_CH | Fatal-error report from the sequencer, one bit per channel |
| fetchStart | output | NUM_CH | One-cycle descriptor fetch pulse per channel |
| chActive | output | NUM_CH | ACTIVE status bit per channel |

## Verification
The bench covers the following corner cases:
- **Mask bits over protected positions.** A design that let the mask reach DEAD, ACTIVE or branch-taken would clear or set those flags.
- **All controls at once.** RUN, WAKE and PAUSE are set in a single write. A wrong rule order would leave the channel active and emit a fetch pulse.
- **Kill, then control writes.** The bench kills a running channel, then rewrites its controls. A missing DEAD clear on RUN shows up as a stuck DEAD. A missing clear on a RUN fall shows up as DEAD surviving the stop.
- **WAKE on a dead, stopped channel.** This must make the channel active while DEAD stays set.
- **Pointer writes while locked or active-only.** These must leave the old pointer in place. A design that checks only RUN would accept the write and send a spurious fetch pulse.
- **Misaligned pointers.** These expose missing alignment.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int RUN_B   = 15;
  localparam int PAUSE_B = 14;
  localparam int FLUSH_B = 13;
  localparam int WAKE_B  = 12;
  localparam int DEAD_B  = 11;
  localparam int ACT_B   = 10;
  localparam int BT_B    = 8;

  // status bits a control write may reach
  localparam logic [15:0] CTRL_WR_MASK = 16'hF0FF;

  localparam int WORD_W = 5;

  typedef enum logic [WORD_W-1:0] {
    W_CTRL    = 5'd0,
    W_STATUS  = 5'd1,
    W_CMDPTR  = 5'd2,
    W_IRQSEL  = 5'd3,
    W_BRSEL   = 5'd4,
    W_WAITSEL = 5'd5
  } regWord_e;

  typedef struct packed {
    logic ctrlWr;
    logic ptrWr;
    logic irqSelWr;
    logic brSelWr;
    logic waitSelWr;
  } chStrobe_t;

  localparam int STB_W = $bits(chStrobe_t);
endpackage

// File: rtl/dmaRegDecode.sv
module dmaRegDecode
  import dmaRegPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  output chStrobe_t           strobes [NUM_CH],
  output logic [CH_W-1:0]     selCh,
  output logic [WORD_W-1:0]   selWord
);
  logic [1:0] unusedByteLane;
  logic [NUM_CH*STB_W-1:0] flatStb;

  assign selCh          = addr[ADDR_W-1:7];
  assign selWord        = addr[6:2];
  assign unusedByteLane = addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    always_comb begin
      strobes[c] = '0;
      if (wrEn && selCh == CH_W'(c)) begin
        case (selWord)
          W_CTRL:    strobes[c].ctrlWr    = 1'b1;
          W_CMDPTR:  strobes[c].ptrWr     = 1'b1;
          W_IRQSEL:  strobes[c].irqSelWr  = 1'b1;
          W_BRSEL:   strobes[c].brSelWr   = 1'b1;
          W_WAITSEL: strobes[c].waitSelWr = 1'b1;
          default:   strobes[c] = '0;
        endcase
      end
    end
    assign flatStb[c*STB_W +: STB_W] = strobes[c];
  end

  // R9
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flatStb));

  // R8
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> flatStb == '0);
endmodule

// File: rtl/dmaChanRegs.sv
module dmaChanRegs
  import dmaRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chStrobe_t   stb,
  input  logic [31:0] wrData,
  input  logic        killReq,
  output logic [15:0] status,
  output logic [31:0] cmdPtr,
  output logic [31:0] irqSel,
  output logic [31:0] brSel,
  output logic [31:0] waitSel,
  output logic        fetchStart,
  output logic        active
);
  logic [15:0] effMask;
  logic [15:0] merged;
  logic [15:0] derived;
  logic [15:0] statusNext;
  logic        ptrLocked;
  logic        ptrAccept;
  logic        startNext;

  assign effMask   = wrData[31:16] & CTRL_WR_MASK;
  assign merged    = (wrData[15:0] & effMask) | (status & ~effMask);
  assign ptrLocked = status[RUN_B] | status[ACT_B];
  assign ptrAccept = stb.ptrWr & ~ptrLocked;

  always_comb begin
    derived = merged;
    if (derived[WAKE_B]) derived[ACT_B] = 1'b1;
    if (derived[RUN_B]) begin
      derived[ACT_B]  = 1'b1;
      derived[DEAD_B] = 1'b0;
    end
    if (derived[PAUSE_B]) derived[ACT_B] = 1'b0;
    if (status[RUN_B] && !derived[RUN_B]) begin
      derived[ACT_B]  = 1'b0;
      derived[DEAD_B] = 1'b0;
    end
  end

  always_comb begin
    statusNext = stb.ctrlWr ? derived : status;
    if (killReq) begin
      statusNext[DEAD_B] = 1'b1;
      statusNext[ACT_B]  = 1'b0;
    end
  end

  assign startNext = ptrAccept | (stb.ctrlWr & derived[ACT_B] & ~killReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status     <= '0;
      cmdPtr     <= '0;
      irqSel     <= '0;
      brSel      <= '0;
      waitSel    <= '0;
      fetchStart <= 1'b0;
    end else begin
      status     <= statusNext;
      fetchStart <= startNext;
      if (ptrAccept)     cmdPtr  <= {wrData[31:4], 4'h0};
      if (stb.irqSelWr)  irqSel  <= wrData;
      if (stb.brSelWr)   brSel   <= wrData;
      if (stb.waitSelWr) waitSel <= wrData;
    end
  end

  assign active = status[ACT_B];

  // R5
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrWr && (status[RUN_B] || status[ACT_B])) |=> cmdPtr == $past(cmdPtr));

  // R6
  ptr_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrWr && !status[RUN_B] && !status[ACT_B]) |=> fetchStart && cmdPtr[3:0] == 4'h0);

  // R7
  fetch_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchStart |-> $past(stb.ctrlWr || stb.ptrWr));

  // R3
  pause_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[PAUSE_B] |-> !status[ACT_B]);

  // R4
  run_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(status[RUN_B]) && !$past(killReq)) |-> !status[ACT_B] && !status[DEAD_B]);

  // R10
  kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    killReq |=> status[DEAD_B] && !status[ACT_B] && !fetchStart);

  // R2
  bt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlWr |=> status[BT_B] == $past(status[BT_B]));
endmodule

// File: rtl/dmaChanCtrlRegs.sv
module dmaChanCtrlRegs
  import dmaRegPkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = 7 + CH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [NUM_CH-1:0] killReq,
  output logic [NUM_CH-1:0] fetchStart,
  output logic [NUM_CH-1:0] chActive
);
  chStrobe_t         strobes   [NUM_CH];
  logic [CH_W-1:0]   selCh;
  logic [WORD_W-1:0] selWord;
  logic [15:0]       statusArr [NUM_CH];
  logic [31:0]       ptrArr    [NUM_CH];
  logic [31:0]       irqArr    [NUM_CH];
  logic [31:0]       brArr     [NUM_CH];
  logic [31:0]       waitArr   [NUM_CH];

  dmaRegDecode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) decode_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .strobes(strobes), .selCh(selCh), .selWord(selWord)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmaChanRegs chan_i (
      .clk(clk), .rstN(rstN), .stb(strobes[c]), .wrData(wrData),
      .killReq(killReq[c]), .status(statusArr[c]), .cmdPtr(ptrArr[c]),
      .irqSel(irqArr[c]), .brSel(brArr[c]), .waitSel(waitArr[c]),
      .fetchStart(fetchStart[c]), .active(chActive[c])
    );
  end

  always_comb begin
    rdData = '0;
    case (selWord)
      W_STATUS:  rdData = {16'h0, statusArr[selCh]};
      W_CMDPTR:  rdData = ptrArr[selCh];
      W_IRQSEL:  rdData = irqArr[selCh];
      W_BRSEL:   rdData = brArr[selCh];
      W_WAITSEL: rdData = waitArr[selCh];
      default:   rdData = '0;
    endcase
  end

  // R8
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selWord == W_CTRL) |-> rdData == 32'h0);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> fetchStart == '0);
endmodule

// File: tb/dmaChanCtrlRegs_tb_top.sv
module dmaChanCtrlRegs_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 9;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wrData = '0;
  logic [31:0]    rdData;
  logic [NCH-1:0] killReq = '0;
  logic [NCH-1:0] fetchStart;
  logic [NCH-1:0] chActive;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit          chkRd;
    logic [31:0] expRd;
    logic [NCH-1:0] expFs;
    logic [NCH-1:0] expAct;
    string       tag;
  } item_t;
  item_t sbq[$];

  // bench-side model of the visible state
  logic [15:0] mStat [NCH];
  logic [31:0] mPtr  [NCH];
  logic [31:0] mSel  [NCH][3];

  always #2 clk = ~clk;

  dmaChanCtrlRegs #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .killReq(killReq), .fetchStart(fetchStart), .chActive(chActive)
  );

  function automatic logic [AW-1:0] ad(int ch, int w);
    return AW'(ch * 128 + w * 4);
  endfunction

  function automatic logic [NCH-1:0] actVec();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = mStat[c][10];
    return v;
  endfunction

  function automatic logic [15:0] ctrlModel(logic [15:0] old, logic [15:0] m, logic [15:0] v);
    logic [15:0] em;
    logic [15:0] n;
    em = m & 16'hF0FF;
    n  = (v & em) | (old & ~em);
    if (n[12]) n[10] = 1'b1;
    if (n[15]) begin n[10] = 1'b1; n[11] = 1'b0; end
    if (n[14]) n[10] = 1'b0;
    if (old[15] && !n[15]) begin n[10] = 1'b0; n[11] = 1'b0; end
    return n;
  endfunction

  // monitor: one scoreboard item per negedge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (fetchStart !== it.expFs) begin
        errors++;
        $display("FAIL %s fetchStart actual=%b expected=%b", it.tag, fetchStart, it.expFs);
      end
      checks++;
      if (chActive !== it.expAct) begin
        errors++;
        $display("FAIL %s R11 chActive actual=%b expected=%b", it.tag, chActive, it.expAct);
      end
      if (it.chkRd) begin
        checks++;
        if (rdData !== it.expRd) begin
          errors++;
          $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.expRd);
        end
      end
    end
  end

  // all tasks start just after a rising edge
  task automatic readChk(int ch, int w, logic [31:0] exp, string tag);
    item_t it;
    addr = ad(ch, w);
    it.chkRd = 1; it.expRd = exp; it.expFs = '0; it.expAct = actVec(); it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic rawWrite(int ch, int w, logic [31:0] d, logic [NCH-1:0] fs, string tag);
    item_t it;
    addr = ad(ch, w); wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
    it.chkRd = 0; it.expRd = '0; it.expFs = fs; it.expAct = actVec(); it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic ctrlWrite(int ch, logic [15:0] m, logic [15:0] v, string tag);
    logic [NCH-1:0] fs;
    mStat[ch] = ctrlModel(mStat[ch], m, v);
    fs = '0;
    fs[ch] = mStat[ch][10];
    rawWrite(ch, 0, {m, v}, fs, tag);
  endtask

  task automatic ptrWrite(int ch, logic [31:0] d, string tag);
    logic [NCH-1:0] fs;
    fs = '0;
    if (!mStat[ch][15] && !mStat[ch][10]) begin
      mPtr[ch] = {d[31:4], 4'h0};
      fs[ch] = 1'b1;
    end
    rawWrite(ch, 2, d, fs, tag);
  endtask

  task automatic kill(int ch, string tag);
    item_t it;
    killReq[ch] = 1'b1;
    @(posedge clk); #1;
    killReq = '0;
    mStat[ch][11] = 1'b1;
    mStat[ch][10] = 1'b0;
    it.chkRd = 0; it.expRd = '0; it.expFs = '0; it.expAct = actVec(); it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mStat[c] = '0; mPtr[c] = '0;
      for (int s = 0; s < 3; s++) mSel[c][s] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    readChk(0, 1, 32'h0, "R1 status ch0");
    readChk(0, 2, 32'h0, "R1 cmdptr ch0");
    readChk(3, 5, 32'h0, "R1 waitsel ch3");
    readChk(2, 3, 32'h0, "R1 irqsel ch2");

    // R6 aligned pointer write with fetch pulse
    ptrWrite(1, 32'h1234_567F, "R6 ptr write ch1");
    readChk(1, 2, 32'h1234_5670, "R6 ptr aligned ch1");

    // R8 select registers and unused words
    rawWrite(1, 3, 32'hA5A5_0001, '0, "R8 irqsel write");
    rawWrite(1, 4, 32'h5A5A_0002, '0, "R8 brsel write");
    rawWrite(1, 5, 32'h0F0F_0003, '0, "R8 waitsel write");
    readChk(1, 3, 32'hA5A5_0001, "R8 irqsel readback");
    readChk(1, 4, 32'h5A5A_0002, "R8 brsel readback");
    readChk(1, 5, 32'h0F0F_0003, "R8 waitsel readback");
    rawWrite(1, 8, 32'hFFFF_FFFF, '0, "R8 unused word write");
    readChk(1, 8, 32'h0, "R8 unused word reads 0");
    rawWrite(1, 1, 32'hFFFF_FFFF, '0, "R8 direct status write");
    readChk(1, 1, 32'h0, "R8 status not directly writable");

    // R2 R7 RUN start
    ctrlWrite(1, 16'h8000, 16'h8000, "R7 run start ch1");
    readChk(1, 1, 32'h0000_8400, "R2 status after run");
    readChk(1, 0, 32'h0, "R8 control reads 0");

    // R5 locked pointer
    ptrWrite(1, 32'hDEAD_BEE0, "R5 ptr write while running");
    readChk(1, 2, 32'h1234_5670, "R5 ptr unchanged");

    // R3 all controls, pause wins
    ctrlWrite(1, 16'hFFFF, 16'hFFFF, "R3 pause wins no pulse");
    readChk(1, 1, 32'h0000_F0FF, "R3 status pause wins");
    ctrlWrite(1, 16'h4000, 16'h0000, "R3 unpause resumes");
    readChk(1, 1, 32'h0000_B4FF, "R3 status resumed");

    // R10 kill, R3 RUN clears DEAD
    kill(1, "R10 kill ch1");
    readChk(1, 1, 32'h0000_B8FF, "R10 dead set active clear");
    ctrlWrite(1, 16'h1000, 16'h0000, "R3 run rewrite clears dead");
    readChk(1, 1, 32'h0000_A4FF, "R3 dead cleared by run");

    // R4 run falling
    kill(1, "R10 second kill ch1");
    ctrlWrite(1, 16'h8000, 16'h0000, "R4 run fall");
    readChk(1, 1, 32'h0000_20FF, "R4 active and dead cleared");

    // R2 masked device status and protected bits
    ctrlWrite(1, 16'h000F, 16'h0005, "R2 devstat nibble");
    readChk(1, 1, 32'h0000_20F5, "R2 devstat masked merge");
    ctrlWrite(1, 16'h0D00, 16'h0D00, "R2 protected bits");
    readChk(1, 1, 32'h0000_20F5, "R2 protected bits unchanged");

    // R3 wake on dead stopped channel
    kill(2, "R10 kill idle ch2");
    ctrlWrite(2, 16'h1000, 16'h1000, "R3 wake dead ch2");
    readChk(2, 1, 32'h0000_1C00, "R3 wake keeps dead");
    ptrWrite(2, 32'h0000_1000, "R5 ptr write active-only ch2");
    readChk(2, 2, 32'h0, "R5 ptr unchanged active-only");

    // R9 channel independence
    ptrWrite(0, 32'hFFFF_FFFF, "R9 ptr write ch0");
    readChk(0, 2, 32'hFFFF_FFF0, "R6 ptr ch0 aligned");
    readChk(2, 1, 32'h0000_1C00, "R9 ch2 untouched");
    readChk(3, 2, 32'h0, "R9 ch3 untouched");
    readChk(1, 2, 32'h1234_5670, "R9 ch1 ptr kept");
    ptrWrite(1, 32'h0000_0108, "R6 ptr accepted after stop");
    readChk(1, 2, 32'h0000_0100, "R6 ptr ch1 realigned");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule